// File: doc/BRIEF.md
# Dual-Domain Down-Counting Timer

This block is a register-mapped timer with `NCH` independent down-counters, each `W` bits wide. Software programs each channel through a control register, an interval register and a read-only count register. All channels share one interrupt-enable register and one write-1-to-clear interrupt-status register, and the block drives one combined interrupt line. The register file runs on the bus clock. The counters run on a separate timer clock, which is slower than the bus clock and has no phase relation to it. Each channel picks one of `NSRC` tick-enable inputs in the timer clock domain and divides it by a power of two.

A channel counts only after a reload has copied its interval into the counter. When the channel is enabled, the counter falls by one on every prescaled tick. A tick that finds the counter at zero is an expiry. On expiry a periodic channel copies the interval back in and keeps counting, and a one-shot channel stops. If software writes an interval of all ones together with enable and reload, the channel becomes a free-running down-counter that serves as a time base.

Top module: `dtimer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: Register map (byte addresses):
  - interrupt enable at 0x00, with bit n belonging to channel n;
  - interrupt status at 0x04;
  - for channel n, control at 0x10*n+0x10, interval at 0x10*n+0x14 and count at 0x10*n+0x18;
  - the count register is read-only, and writes to it have no effect.
- R3: Control fields:
  - bit 7 selects one-shot (1) or periodic (0);
  - bits 6:4 hold the prescale exponent;
  - bits 3:2 hold the tick-source index;
  - bit 0 is enable;
  - all of these read back as written.
- R4: Writing control bit 1 as 1 loads the interval into the counter on a timer clock edge once the request has crossed domains, whether or not the channel is enabled. Bit 1 reads 1 while the load is pending and 0 after it completes.
- R5: In periodic mode, a tick at count 0 raises an expiry, reloads the interval and keeps counting. The count stays within 0..interval.
- R6: In one-shot mode, after one expiry the counter stays at 0 and raises no further expiry until the next reload.
- R7: Clearing enable stops the counter within two timer clock cycles of the synchronised write, and the count then holds its value.
- R8: A prescale exponent p lets the counter move on every 2^p-th selected tick, so one period is (interval+1)*2^p ticks.
- R9: The source index s makes the channel count only on timer clock edges where `src_tick_i[s]` is high.
- R10: An expiry on channel n sets status bit n. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R11: `irq_o` is the registered OR over all channels of (status AND enable).
- R12: A read of the count register returns a value the counter actually held, never a torn mix of two values. The values read from a running channel never increase between two reloads.
- R13: With an interval of all ones, the channel counts down from 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset, bus domain |
| tclk_i | input | 1 | Timer clock, asynchronous to clk_i |
| src_tick_i | input | NSRC | Tick enables in the timer clock domain |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check the following:
- the status bits honour write-1-to-clear and write-0-to-keep;
- the interrupt line stays low whenever no channel is enabled for interrupts;
- a load places the interval in the counter;
- a disabled or spent one-shot counter never moves.

The scenarios show what needs a whole sequence of events:
- expiry timing under different prescalers and tick sources;
- the periodic restart;
- the pending-then-clear reload bit;
- the value held after a disable crosses domains;
- the monotonic, untorn readback of a free-running channel.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  // control fields as they sit in the control register from bit 7 down to bit 2, enable last
  typedef struct packed {
    logic       oneshot;
    logic [2:0] presc;
    logic [1:0] sel;
    logic       en;
  } ctl_t;

  localparam int IE_OFS    = 'h00;
  localparam int ST_OFS    = 'h04;
  localparam int CH_BASE   = 'h10;
  localparam int CH_STRIDE = 'h10;
  localparam int CTL_SUB   = 'h0;
  localparam int IVL_SUB   = 'h4;
  localparam int CNT_SUB   = 'h8;
  localparam int PCNT_W    = 7;
endpackage

// File: rtl/dt_sync.sv
module dt_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dt_chan.sv
module dt_chan
  import dtimer_pkg::*;
#(
  parameter int W    = 32,
  parameter int NSRC = 4
) (
  input  logic            tclk_i,
  input  logic            rst_i,
  input  ctl_t            ctl_i,
  input  logic            rl_tgl_i,
  input  logic            snap_tgl_i,
  input  logic [NSRC-1:0] ticks_i,
  input  logic [W-1:0]    ival_i,
  output logic            rl_ack_o,
  output logic            snap_ack_o,
  output logic            exp_tgl_o,
  output logic [W-1:0]    cnt_o,
  output logic [W-1:0]    hold_o,
  output logic            armed_o,
  output logic            load_o
);
  logic              tick;
  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] pmask;
  logic              pterm;
  logic              load;

  // R9: pick the tick source named by the control field
  always_comb begin
    tick = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      if (ctl_i.sel == 2'(s)) tick = ticks_i[s];
    end
  end

  // R8: every 2^p-th tick passes
  assign pmask = PCNT_W'((8'd1 << ctl_i.presc) - 8'd1);
  assign pterm = (pcnt_q & pmask) == pmask;
  assign load  = rl_tgl_i != rl_ack_o;

  always_ff @(posedge tclk_i) begin
    if (rst_i) begin
      cnt_o      <= '0;
      pcnt_q     <= '0;
      armed_o    <= 1'b0;
      rl_ack_o   <= 1'b0;
      exp_tgl_o  <= 1'b0;
      hold_o     <= '0;
      snap_ack_o <= 1'b0;
    end else begin
      if (load) begin
        // R4: reload copies the interval in
        cnt_o    <= ival_i;
        armed_o  <= 1'b1;
        pcnt_q   <= '0;
        rl_ack_o <= ~rl_ack_o;
      end else if (ctl_i.en && armed_o && tick) begin
        pcnt_q <= pcnt_q + 1'b1;
        if (pterm) begin
          if (cnt_o == '0) begin
            exp_tgl_o <= ~exp_tgl_o;
            if (ctl_i.oneshot) armed_o <= 1'b0;  // R6
            else               cnt_o   <= ival_i; // R5
          end else begin
            cnt_o <= cnt_o - 1'b1;
          end
        end
      end
      // R12: capture a whole value for the bus side, then acknowledge
      if (snap_tgl_i != snap_ack_o) begin
        hold_o     <= cnt_o;
        snap_ack_o <= ~snap_ack_o;
      end
    end
  end

  assign load_o = load;
endmodule

// File: rtl/dtimer.sv
module dtimer
  import dtimer_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int W    = 32,
  parameter int AW   = 8,
  parameter int NSRC = 4
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            tclk_i,
  input  logic [NSRC-1:0] src_tick_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic            irq_o
);
  localparam int CTLW = $bits(ctl_t);
  localparam int FWDW = CTLW + 2;

  function automatic logic [AW-1:0] ch_addr(input int c, input int sub);
    return AW'(CH_BASE + CH_STRIDE * c + sub);
  endfunction

  // bus domain state
  ctl_t [NCH-1:0]         ctl_q;
  logic [NCH-1:0][W-1:0]  ival_q, shadow_q;
  logic [NCH-1:0]         ie_q, st_q, rl_req_q, snap_req_q, exp_d_q;
  logic [NCH-1:0]         rl_ack_b, snap_ack_b, exp_b, rl_busy, st_set, st_clr;
  logic [31:0]            rd_mux;

  // timer domain state
  logic [1:0]             trst_q = 2'b11;
  logic                   rst_s;
  ctl_t [NCH-1:0]         ctl_s;
  logic [NCH-1:0]         rl_tgl_s, snap_tgl_s, rl_ack_s, snap_ack_s, exp_tgl_s;
  logic [NCH-1:0]         en_s, armed_s, load_s;
  logic [NCH-1:0][W-1:0]  cnt_s, hold_s;

  always_ff @(posedge tclk_i) trst_q <= {trst_q[0], rst_i};
  assign rst_s = trst_q[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [FWDW-1:0] fwd_q;
    logic [2:0]      back_q;

    // R7: control and request toggles reach the timer domain in two flops
    dt_sync #(.W(FWDW)) u_fwd (
      .clk_i(tclk_i), .rst_i(rst_s),
      .d_i({ctl_q[c], rl_req_q[c], snap_req_q[c]}), .q_o(fwd_q)
    );
    assign ctl_s[c]      = fwd_q[FWDW-1:2];
    assign rl_tgl_s[c]   = fwd_q[1];
    assign snap_tgl_s[c] = fwd_q[0];
    assign en_s[c]       = ctl_s[c].en;

    dt_sync #(.W(3)) u_back (
      .clk_i(clk_i), .rst_i(rst_i),
      .d_i({rl_ack_s[c], snap_ack_s[c], exp_tgl_s[c]}), .q_o(back_q)
    );
    assign rl_ack_b[c]   = back_q[2];
    assign snap_ack_b[c] = back_q[1];
    assign exp_b[c]      = back_q[0];
    assign rl_busy[c]    = rl_req_q[c] != rl_ack_b[c];
    assign st_set[c]     = exp_b[c] ^ exp_d_q[c];

    dt_chan #(.W(W), .NSRC(NSRC)) u_chan (
      .tclk_i(tclk_i), .rst_i(rst_s), .ctl_i(ctl_s[c]),
      .rl_tgl_i(rl_tgl_s[c]), .snap_tgl_i(snap_tgl_s[c]),
      .ticks_i(src_tick_i), .ival_i(ival_q[c]),
      .rl_ack_o(rl_ack_s[c]), .snap_ack_o(snap_ack_s[c]),
      .exp_tgl_o(exp_tgl_s[c]), .cnt_o(cnt_s[c]), .hold_o(hold_s[c]),
      .armed_o(armed_s[c]), .load_o(load_s[c])
    );
  end

  // R10: write-1-to-clear mask
  assign st_clr = (wr_en_i && addr_i == AW'(ST_OFS)) ? wdata_i[NCH-1:0] : '0;

  // R2: read decode
  always_comb begin
    rd_mux = '0;
    if (addr_i == AW'(IE_OFS)) rd_mux[NCH-1:0] = ie_q;
    if (addr_i == AW'(ST_OFS)) rd_mux[NCH-1:0] = st_q;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == ch_addr(c, CTL_SUB))
        rd_mux = 32'({ctl_q[c].oneshot, ctl_q[c].presc, ctl_q[c].sel, rl_busy[c], ctl_q[c].en});
      if (addr_i == ch_addr(c, IVL_SUB)) rd_mux = 32'(ival_q[c]);
      if (addr_i == ch_addr(c, CNT_SUB)) rd_mux = 32'(shadow_q[c]);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctl_q      <= '0;
      ival_q     <= '0;
      shadow_q   <= '0;
      ie_q       <= '0;
      st_q       <= '0;
      rl_req_q   <= '0;
      snap_req_q <= '0;
      exp_d_q    <= '0;
      irq_o      <= 1'b0;
      rdata_o    <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (wr_en_i && addr_i == ch_addr(c, CTL_SUB)) begin
          ctl_q[c] <= ctl_t'({wdata_i[7:2], wdata_i[0]});
          if (wdata_i[1] && !rl_busy[c]) rl_req_q[c] <= ~rl_req_q[c];
        end
        if (wr_en_i && addr_i == ch_addr(c, IVL_SUB)) ival_q[c] <= W'(wdata_i);
        // R12: copy the held value only while the timer side leaves it alone
        if (snap_ack_b[c] == snap_req_q[c]) begin
          shadow_q[c]   <= hold_s[c];
          snap_req_q[c] <= ~snap_req_q[c];
        end
      end
      if (wr_en_i && addr_i == AW'(IE_OFS)) ie_q <= wdata_i[NCH-1:0];
      exp_d_q <= exp_b;
      st_q    <= (st_q & ~st_clr) | st_set;
      irq_o   <= |(st_q & ie_q);  // R11
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/dtimer_chk.sv
module dtimer_chk #(
  parameter int NCH    = 2,
  parameter int W      = 32,
  parameter int AW     = 8,
  parameter int ST_ADR = 4
) (
  input logic                  clk_i,
  input logic                  rst_i,
  input logic                  tclk_i,
  input logic                  rst_s,
  input logic                  wr_en_i,
  input logic [AW-1:0]         addr_i,
  input logic [31:0]           wdata_i,
  input logic                  irq_o,
  input logic [NCH-1:0]        ie_q,
  input logic [NCH-1:0]        st_q,
  input logic [NCH-1:0]        st_set,
  input logic [NCH-1:0]        en_s,
  input logic [NCH-1:0]        armed_s,
  input logic [NCH-1:0]        load_s,
  input logic [NCH-1:0][W-1:0] cnt_s,
  input logic [NCH-1:0][W-1:0] ival_q
);
  a_r11_irq_masked: assert property (@(posedge clk_i) disable iff (rst_i)
    ie_q == '0 |=> !irq_o);

  a_r11_irq_cause: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> $past(st_q != '0));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    a_r10_w0_keeps: assert property (@(posedge clk_i) disable iff (rst_i)
      st_q[c] && !(wr_en_i && addr_i == AW'(ST_ADR) && wdata_i[c]) |=> st_q[c]);

    a_r10_w1_clears: assert property (@(posedge clk_i) disable iff (rst_i)
      wr_en_i && addr_i == AW'(ST_ADR) && wdata_i[c] && !st_set[c] |=> !st_q[c]);

    a_r4_load_value: assert property (@(posedge tclk_i) disable iff (rst_s)
      load_s[c] |=> cnt_s[c] == $past(ival_q[c]));

    a_r7_frozen: assert property (@(posedge tclk_i) disable iff (rst_s)
      !en_s[c] && !load_s[c] |=> $stable(cnt_s[c]));

    a_r6_spent: assert property (@(posedge tclk_i) disable iff (rst_s)
      !armed_s[c] && !load_s[c] |=> $stable(cnt_s[c]));
  end
endmodule

bind dtimer dtimer_chk #(.NCH(NCH), .W(W), .AW(AW), .ST_ADR(dtimer_pkg::ST_OFS)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .tclk_i(tclk_i), .rst_s(rst_s),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .irq_o(irq_o),
  .ie_q(ie_q), .st_q(st_q), .st_set(st_set), .en_s(en_s),
  .armed_s(armed_s), .load_s(load_s), .cnt_s(cnt_s), .ival_q(ival_q)
);

// File: tb/dtimer_bench.sv
module dtimer_bench;
  logic        clk = 1'b0;
  logic        tclk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  src_tick = 4'b0011;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        rv = 1'b0;
  int          checks = 0, errors = 0;
  logic [31:0] va, vb;

  typedef struct {
    logic [31:0] lo;
    logic [31:0] hi;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;   // 50 MHz
  always #35 tclk = ~tclk; // slower, unrelated timer clock

  dtimer u_dtimer (
    .clk_i(clk), .rst_i(rst), .tclk_i(tclk), .src_tick_i(src_tick),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk) rv <= rd_en;

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rv && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (rdata < e.lo || rdata > e.hi) begin
        errors++;
        $display("FAIL %s: got %h expected %h..%h", e.tag, rdata, e.lo, e.hi);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_rng(input logic [7:0] a, input logic [31:0] lo, input logic [31:0] hi, input string tag);
    exp_t e;
    e.lo = lo; e.hi = hi; e.tag = tag;
    @(negedge clk); rd_en = 1'b1; addr = a; exp_q.push_back(e);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] v, input string tag);
    rd_rng(a, v, v, tag);
  endtask

  task automatic rd_now(input logic [7:0] a, output logic [31:0] v);
    wait (exp_q.size() == 0);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  task automatic wait_t(input int n);
    repeat (n) @(posedge tclk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (10) @(posedge tclk);
    @(negedge clk); rst = 1'b0;
    wait_t(4);

    // R1 reset state
    rd_exp(8'h00, 0, "R1 ie");
    rd_exp(8'h04, 0, "R1 status");
    rd_exp(8'h10, 0, "R1 ctl0");
    rd_exp(8'h14, 0, "R1 ival0");
    rd_exp(8'h18, 0, "R1 cnt0");
    rd_exp(8'h20, 0, "R1 ctl1");
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);

    // R2 map, count register ignores writes
    wr(8'h14, 5);
    rd_exp(8'h14, 5, "R2 ival0");
    wr(8'h18, 32'hDEAD_BEEF);
    wait_t(10);
    rd_exp(8'h18, 0, "R2 cnt write ignored");

    // R3 control fields
    wr(8'h20, 32'hF5);
    rd_exp(8'h20, 32'hF5, "R3 ctl1 fields");
    wr(8'h20, 0);

    // R4 reload while disabled
    wr(8'h10, 32'h02);
    rd_exp(8'h10, 32'h02, "R4 reload pending");
    wait_t(10);
    rd_exp(8'h10, 0, "R4 reload self-clears");
    rd_exp(8'h18, 5, "R4 interval loaded");
    wait_t(10);
    rd_exp(8'h18, 5, "R7 disabled holds");

    // R6 one-shot
    wr(8'h10, 32'h83);
    wait_t(40);
    rd_exp(8'h18, 0, "R6 one-shot at zero");
    rd_exp(8'h04, 1, "R10 expiry sets status");
    chk(irq == 1'b0, "R11 masked irq", 32'(irq), 0);
    wr(8'h04, 0);
    rd_exp(8'h04, 1, "R10 write 0 keeps");
    wr(8'h04, 1);
    rd_exp(8'h04, 0, "R10 write 1 clears");
    wait_t(40);
    rd_exp(8'h04, 0, "R6 no second expiry");
    rd_exp(8'h18, 0, "R6 stays at zero");
    wr(8'h00, 1);
    wait_t(2);
    chk(irq == 1'b0, "R11 no status no irq", 32'(irq), 0);

    // R5 periodic
    wr(8'h14, 3);
    wr(8'h10, 32'h03);
    wait_t(20);
    rd_exp(8'h04, 1, "R5 periodic expiry");
    chk(irq == 1'b1, "R11 irq asserted", 32'(irq), 1);
    rd_rng(8'h18, 0, 3, "R5 count in range");
    rd_rng(8'h18, 0, 3, "R5 count in range again");
    wr(8'h04, 1);
    wait_t(20);
    rd_exp(8'h04, 1, "R5 keeps running");

    // R7 disable stops expiries
    wr(8'h10, 0);
    wait_t(10);
    wr(8'h04, 1);
    wait_t(30);
    rd_exp(8'h04, 0, "R7 stopped no expiry");
    chk(irq == 1'b0, "R11 irq falls", 32'(irq), 0);

    // R7 held value after disable
    wr(8'h14, 1000);
    wr(8'h10, 32'h03);
    wait_t(20);
    wr(8'h10, 0);
    wait_t(10);
    rd_now(8'h18, va);
    chk(va >= 965 && va <= 995, "R7 value at stop", va, 980);
    wait_t(20);
    rd_exp(8'h18, va, "R7 value held");

    // R8 prescaler 2^3 on channel 1, one-shot, interval 2
    wr(8'h04, 3);
    wr(8'h24, 2);
    wr(8'h20, 32'hB3);
    wait_t(16);
    rd_exp(8'h04, 0, "R8 not yet expired");
    wait_t(30);
    rd_exp(8'h04, 2, "R8 expired after 24 ticks");
    rd_exp(8'h28, 0, "R8 count zero");

    // R9 tick source 2 held low, then released
    wr(8'h04, 2);
    wr(8'h20, 32'h8B);
    wait_t(30);
    rd_exp(8'h28, 2, "R9 idle source no count");
    rd_exp(8'h04, 0, "R9 idle source no expiry");
    @(negedge tclk); src_tick[2] = 1'b1;
    wait_t(20);
    rd_exp(8'h04, 2, "R9 active source expires");
    rd_exp(8'h28, 0, "R9 count zero");

    // R13 free-running, R12 monotonic readback
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h20, 32'h03);
    wait_t(30);
    rd_now(8'h28, va);
    chk(va >= 32'hFFFF_FFFF - 40 && va <= 32'hFFFF_FFFF - 10, "R13 free-running start", va, 32'hFFFF_FFE0);
    wait_t(10);
    rd_now(8'h28, vb);
    chk(vb < va && (va - vb) >= 5 && (va - vb) <= 15, "R12 step between reads", va - vb, 10);
    for (int i = 0; i < 8; i++) begin
      va = vb;
      wait_t(1);
      rd_now(8'h28, vb);
      chk(vb <= va && (va - vb) <= 4, "R12 untorn monotonic", vb, va);
    end

    wait (exp_q.size() == 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule